// File: doc/BRIEF.md
# Sliding-Window Amplitude Overload Detector

This block watches a wide parallel stream of baseband samples and flags an overload. Each clock it can take eight I samples and eight Q samples, all in two's complement. When the average amplitude over a recent window goes above a programmed limit, it raises a trigger. A gain-reduction stage downstream would use that trigger to protect a power amplifier.

The I and Q components are handled in two identical paths:

- Each sample is turned into a coarse magnitude.
- The eight magnitudes of a clock are added into one word.
- A running accumulator keeps the sum of the most recent N valid words. It adds the newest word and takes away the word leaving a delay line of selectable length.
- The sum is divided by N with rounding and compared with the threshold.

Either path going over the limit fires the shared trigger. The trigger is registered.

Top module: `amp_overload_det`

## Requirements
- R1: `win_sel` sets the window length N: 2'b00 gives 32 words, 2'b01 gives 64, 2'b10 gives 128, and the reserved code 2'b11 also gives 128.
- R2: Each 16-bit lane sample is read as two's complement. Its absolute value (which reaches 32768 for the most negative code) is divided by 128 with truncation, which gives a 9-bit magnitude.
- R3: In each path, the eight lane magnitudes of a clock are added into one 12-bit word. Lane k sits in bits [16k+15:16k] of its bus, and a word never exceeds 2048.
- R4: Only cycles with `in_valid` high add a word to a path's history. In cycles with `in_valid` low, nothing changes.
- R5: The average of a path is (S + N/2) / N truncated, where S is the sum of the last N valid words. This is round-half-up to an integer.
- R6: The trigger fires when the I average or the Q average is strictly greater than `thresh`. An average equal to `thresh` does not fire it.
- R7: The trigger stays low until N valid words have been collected since the last reset or window change.
- R8: A cycle in which `win_sel` differs from the window in use clears all history. Any sample presented in that cycle is discarded, and the new N applies from the next cycle.
- R9: `trig_o` is registered. The value seen after rising edge e reflects the history held after edge e-1, compared against the `thresh` applied before edge e.
- R10: While `rst_n` is low, `trig_o` is low and all history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample buses carry a valid clock of data |
| i_samples | input | 128 | Eight 16-bit I samples, lane k at [16k+15:16k] |
| q_samples | input | 128 | Eight 16-bit Q samples, same packing |
| win_sel | input | 2 | Window length code |
| thresh | input | 13 | Average-amplitude limit |
| trig_o | output | 1 | Overload trigger |

## Verification
The hardest condition to reach from the ports is an average that lands exactly on a rounding boundary or exactly on the threshold. At those points the outcome depends on a single LSB of a 19-bit sum. The stimulus gets there in two ways. It fills a cleared window with identical words so that the average is known exactly, then moves `thresh` across that value. It also builds windows that hold one small nonzero word among zeros, so that the sum is N/2 or N/2 - 1. Window changes are driven in the middle of a run, so that the history clears and the fill delay starts over for every length code.

// File: rtl/amp_ovl_pkg.sv
package amp_ovl_pkg;

  typedef enum logic [1:0] {
    WIN_32   = 2'b00,
    WIN_64   = 2'b01,
    WIN_128  = 2'b10,
    WIN_RSVD = 2'b11
  } win_code_e;

  // log2 of the window length; the reserved code falls back to the longest
  function automatic logic [2:0] win_shift(input win_code_e c);
    case (c)
      WIN_32:  return 3'd5;
      WIN_64:  return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/amp_word_sum.sv
module amp_word_sum #(
  parameter int LANES  = 8,
  parameter int SAMP_W = 16,
  parameter int MAG_W  = 9,
  parameter int WORD_W = 12
) (
  input  logic [LANES*SAMP_W-1:0] samples,
  output logic [WORD_W-1:0]       word
);

  localparam int DROP = SAMP_W - MAG_W;

  function automatic logic [MAG_W-1:0] mag_of(input logic [SAMP_W-1:0] s);
    logic [SAMP_W-1:0] a;
    a = s[SAMP_W-1] ? (~s + 1'b1) : s;
    return MAG_W'(a >> DROP);
  endfunction

  logic [MAG_W-1:0] mags [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mags[k] = mag_of(samples[k*SAMP_W +: SAMP_W]);
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < LANES; k++) word = word + WORD_W'(mags[k]);
  end

endmodule

// File: rtl/amp_window_acc.sv
module amp_window_acc #(
  parameter int WORD_W = 12,
  parameter int ACC_W  = 19,
  parameter int AVG_W  = 13,
  parameter int MAX_SH = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [WORD_W-1:0] word_in,
  input  logic [2:0]        n_shift,
  output logic [ACC_W-1:0]  acc_o,
  output logic [AVG_W-1:0]  avg_o
);

  localparam int DEPTH = 1 << MAX_SH;
  localparam int IDX_W = MAX_SH;

  logic [WORD_W-1:0] line [DEPTH];
  logic [IDX_W-1:0]  tap_idx;
  logic [WORD_W-1:0] leaving;
  logic [ACC_W-1:0]  acc_q;

  function automatic logic [AVG_W-1:0] round_avg(input logic [ACC_W-1:0] s,
                                                  input logic [2:0] sh);
    logic [ACC_W:0] t;
    t = {1'b0, s} + ((ACC_W+1)'(1) << (sh - 3'd1));
    t = t >> sh;
    return AVG_W'(t);
  endfunction

  assign tap_idx = IDX_W'((32'd1 << n_shift) - 32'd1);
  assign leaving = line[tap_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < DEPTH; k++) line[k] <= '0;
      acc_q <= '0;
    end else if (push) begin
      line[0] <= word_in;
      for (int k = 1; k < DEPTH; k++) line[k] <= line[k-1];
      acc_q <= acc_q + ACC_W'(word_in) - ACC_W'(leaving);
    end
  end

  assign acc_o = acc_q;
  assign avg_o = round_avg(acc_q, n_shift);

endmodule

// File: rtl/amp_overload_det.sv
module amp_overload_det
  import amp_ovl_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int SAMP_W  = 16,
  parameter int MAG_W   = 9,
  parameter int WORD_W  = 12,
  parameter int ACC_W   = 19,
  parameter int AVG_W   = 13,
  parameter int MAX_WIN = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*SAMP_W-1:0] i_samples,
  input  logic [LANES*SAMP_W-1:0] q_samples,
  input  logic [1:0]              win_sel,
  input  logic [AVG_W-1:0]        thresh,
  output logic                    trig_o
);

  localparam int MAX_SH = $clog2(MAX_WIN);
  localparam int FILL_W = $clog2(MAX_WIN + 1);
  localparam int PATHS  = 2;

  win_code_e         win_q;
  logic              win_chg;
  logic [2:0]        n_shift;
  logic [FILL_W-1:0] win_len;
  logic [FILL_W-1:0] fill;
  logic              win_full;
  logic              trig_q;

  logic [LANES*SAMP_W-1:0] bus_p  [PATHS];
  logic [WORD_W-1:0]       word_p [PATHS];
  logic [ACC_W-1:0]        acc_p  [PATHS];
  logic [AVG_W-1:0]        avg_p  [PATHS];
  logic [PATHS-1:0]        over_p;

  // named views for the bound checker
  logic [WORD_W-1:0] word_i, word_q;
  logic [ACC_W-1:0]  acc_i, acc_q;
  logic [AVG_W-1:0]  avg_i, avg_q;

  assign win_chg  = (win_code_e'(win_sel) != win_q);
  assign n_shift  = win_shift(win_q);
  assign win_len  = FILL_W'(1) << n_shift;
  assign win_full = (fill == win_len);

  assign bus_p[0] = i_samples;
  assign bus_p[1] = q_samples;

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    amp_word_sum #(
      .LANES(LANES), .SAMP_W(SAMP_W), .MAG_W(MAG_W), .WORD_W(WORD_W)
    ) u_sum (
      .samples(bus_p[p]),
      .word   (word_p[p])
    );

    amp_window_acc #(
      .WORD_W(WORD_W), .ACC_W(ACC_W), .AVG_W(AVG_W), .MAX_SH(MAX_SH)
    ) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (win_chg),
      .push   (in_valid),
      .word_in(word_p[p]),
      .n_shift(n_shift),
      .acc_o  (acc_p[p]),
      .avg_o  (avg_p[p])
    );

    assign over_p[p] = (avg_p[p] > thresh);
  end

  assign word_i = word_p[0];
  assign word_q = word_p[1];
  assign acc_i  = acc_p[0];
  assign acc_q  = acc_p[1];
  assign avg_i  = avg_p[0];
  assign avg_q  = avg_p[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= WIN_32;
      fill   <= '0;
      trig_q <= 1'b0;
    end else begin
      win_q  <= win_code_e'(win_sel);
      trig_q <= win_full && (|over_p);
      if (win_chg)
        fill <= '0;
      else if (in_valid && !win_full)
        fill <= fill + 1'b1;
    end
  end

  assign trig_o = trig_q;

endmodule

// File: rtl/amp_ovl_chk.sv
module amp_ovl_chk #(
  parameter int LANES  = 8,
  parameter int MAG_W  = 9,
  parameter int WORD_W = 12,
  parameter int ACC_W  = 19,
  parameter int AVG_W  = 13,
  parameter int FILL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              win_chg,
  input logic              win_full,
  input logic [FILL_W-1:0] fill,
  input logic [WORD_W-1:0] word_i,
  input logic [WORD_W-1:0] word_q,
  input logic [ACC_W-1:0]  acc_i,
  input logic [ACC_W-1:0]  acc_q,
  input logic [AVG_W-1:0]  avg_i,
  input logic [AVG_W-1:0]  avg_q,
  input logic [AVG_W-1:0]  thresh,
  input logic              trig_o
);

  localparam logic [WORD_W-1:0] WORD_MAX = WORD_W'(LANES << (MAG_W - 1));

  // R3
  word_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_i <= WORD_MAX) && (word_q <= WORD_MAX));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !win_chg) |=> ($stable(acc_i) && $stable(acc_q)));

  // R4
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !win_chg && !win_full) |=>
      (acc_i == ACC_W'($past(acc_i) + ACC_W'($past(word_i)))) &&
      (acc_q == ACC_W'($past(acc_q) + ACC_W'($past(word_q)))));

  // R7
  early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_full |=> !trig_o);

  // R8
  clear_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_chg |=> (acc_i == '0) && (acc_q == '0) && (fill == '0));

  // R6
  trig_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(win_full) &&
      (($past(avg_i) > $past(thresh)) || ($past(avg_q) > $past(thresh))));

endmodule

bind amp_overload_det amp_ovl_chk #(
  .LANES(LANES), .MAG_W(MAG_W), .WORD_W(WORD_W),
  .ACC_W(ACC_W), .AVG_W(AVG_W), .FILL_W(FILL_W)
) u_ovl_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .win_chg(win_chg),
  .win_full(win_full), .fill(fill), .word_i(word_i), .word_q(word_q),
  .acc_i(acc_i), .acc_q(acc_q), .avg_i(avg_i), .avg_q(avg_q),
  .thresh(thresh), .trig_o(trig_o)
);

// File: tb/test_amp_overload_det.sv
module test_amp_overload_det;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] i_samples = '0;
  logic [127:0] q_samples = '0;
  logic [1:0]   win_sel = 2'b00;
  logic [12:0]  thresh = '0;
  logic         trig_o;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;
  exp_t sb[$];

  // reference model state
  int hist_i[$];
  int hist_q[$];
  int m_win = 0;
  bit s_full = 1'b0;
  int s_avg_i = 0;
  int s_avg_q = 0;

  always #5 clk = ~clk;

  amp_overload_det i_amp_overload_det (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .i_samples(i_samples), .q_samples(q_samples),
    .win_sel(win_sel), .thresh(thresh), .trig_o(trig_o)
  );

  function automatic int n_of(int code);
    return (code == 0) ? 32 : (code == 1) ? 64 : 128;  // R1
  endfunction

  function automatic int word_of(logic [127:0] bus);
    int w = 0;
    for (int k = 0; k < 8; k++) begin
      int v;
      int a;
      v = int'($signed(bus[k*16 +: 16]));
      a = (v < 0) ? -v : v;
      w += a / 128;  // R2
    end
    return w;
  endfunction

  function automatic int win_avg(int hq[$], int n);
    int s = 0;
    int cnt = 0;
    for (int k = hq.size() - 1; k >= 0 && cnt < n; k--) begin
      s += hq[k];
      cnt++;
    end
    return (s + n / 2) / n;  // R5
  endfunction

  function automatic logic [127:0] all_lanes(int v);
    logic [127:0] b;
    for (int k = 0; k < 8; k++) b[k*16 +: 16] = 16'(v);
    return b;
  endfunction

  function automatic logic [127:0] one_lane(int v);
    logic [127:0] b = '0;
    b[15:0] = 16'(v);
    return b;
  endfunction

  task automatic step(bit v, logic [127:0] ib, logic [127:0] qb,
                      int code, int thr, string tag);
    exp_t e;
    int n;
    @(negedge clk);
    in_valid  = v;
    i_samples = ib;
    q_samples = qb;
    win_sel   = 2'(code);
    thresh    = 13'(thr);
    // R9: the trigger after this edge reflects the history before it
    e.exp = s_full && ((s_avg_i > thr) || (s_avg_q > thr));
    e.tag = tag;
    sb.push_back(e);
    if (code != m_win) begin
      hist_i.delete();
      hist_q.delete();
      m_win = code;
    end else if (v) begin
      hist_i.push_back(word_of(ib));
      hist_q.push_back(word_of(qb));
      if (hist_i.size() > 128) begin
        void'(hist_i.pop_front());
        void'(hist_q.pop_front());
      end
    end
    n = n_of(m_win);
    s_full  = (hist_i.size() >= n);
    s_avg_i = win_avg(hist_i, n);
    s_avg_q = win_avg(hist_q, n);
  endtask

  // monitor: compares the trigger 2 ns after every edge
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (trig_o !== e.exp) begin
          errors++;
          $display("FAIL %s trig_o actual=%0b expected=%0b", e.tag, trig_o, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int thr;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (trig_o !== 1'b0) begin
      errors++;
      $display("FAIL R10 trig_o in reset actual=%0b expected=0", trig_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R7 R1: window 32 fills with large I words, trigger only after 32
    for (int k = 0; k < 40; k++)
      step(1'b1, all_lanes(32767), '0, 0, 100, "R7 fill32");

    // R4: idle cycles leave the state alone
    for (int k = 0; k < 8; k++)
      step(1'b0, all_lanes(1), all_lanes(32767), 0, 100, "R4 idle");

    // R6: exact average 40 against the threshold
    for (int k = 0; k < 32; k++)
      step(1'b1, all_lanes(640), '0, 0, 40, "R6 equal");
    for (int k = 0; k < 3; k++)
      step(1'b0, '0, '0, 0, 40, "R6 equal");
    for (int k = 0; k < 3; k++)
      step(1'b0, '0, '0, 0, 39, "R6 above");
    for (int k = 0; k < 3; k++)
      step(1'b0, '0, '0, 0, 40, "R6 equal");

    // R6 R2: Q path alone at the most negative code
    for (int k = 0; k < 34; k++)
      step(1'b1, '0, all_lanes(-32768), 0, 1000, "R6 q_only");

    // R8 R5: clear, then sum 16 over 32 rounds up to 1
    step(1'b0, '0, '0, 1, 0, "R8 change");
    step(1'b1, all_lanes(32767), '0, 0, 0, "R8 change");
    for (int k = 0; k < 31; k++)
      step(1'b1, one_lane(-127), '0, 0, 0, "R5 round_zero");
    step(1'b1, one_lane(2048), '0, 0, 0, "R5 round_up");
    for (int k = 0; k < 3; k++)
      step(1'b0, '0, '0, 0, 0, "R5 round_up");

    // R5: sum 15 over 32 rounds down to 0
    step(1'b0, '0, '0, 2, 0, "R8 change");
    step(1'b0, '0, '0, 0, 0, "R8 change");
    for (int k = 0; k < 31; k++)
      step(1'b1, '0, '0, 0, 0, "R5 round_down");
    step(1'b1, '0, one_lane(-1920), 0, 0, "R5 round_down");
    for (int k = 0; k < 3; k++)
      step(1'b0, '0, '0, 0, 0, "R5 round_down");

    // R1: 64, 128 and the reserved code
    for (int k = 0; k < 70; k++)
      step(1'b1, all_lanes(-129), '0, 1, 7, "R1 win64");
    for (int k = 0; k < 132; k++)
      step(1'b1, '0, all_lanes(20000), 3, 100, "R1 win_rsvd");
    for (int k = 0; k < 132; k++)
      step(k % 3 != 0, all_lanes(5000), all_lanes(-3000), 2, 30, "R1 win128");

    // R3 R4 R6: random lanes, valid and threshold
    for (int k = 0; k < 400; k++) begin
      logic [127:0] ib;
      logic [127:0] qb;
      for (int j = 0; j < 4; j++) begin
        ib[j*32 +: 32] = $urandom;
        qb[j*32 +: 32] = $urandom;
      end
      thr = 950 + int'($urandom % 200);
      step(($urandom % 4) != 0, ib, qb, (k < 200) ? 0 : 1, thr, "R3 random");
    end

    for (int k = 0; k < 4; k++)
      step(1'b0, '0, '0, 1, 8191, "R9 drain");
    wait (sb.size() == 0);
    @(posedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule